// File: doc/BRIEF.md
# Desktop Serial Bus Host Transaction Sequencer

This block is the host side of a two-line handshake with a desktop-bus transceiver. It drives a 2-bit phase code toward the transceiver and reads back an active-low controller status line. A byte-wide shift engine moves the data. The sequencer loads that engine or drains it, and it moves one step each time the engine reports a finished byte. The status level and the phase code seen together at each finished byte decide three things: whether the transfer turns around, whether a reply is captured, and whether the transfer has ended in a timeout or a service request.

A request holds a byte count, the bytes themselves (byte 0 is the command) and a reply-wanted flag. The block reports each captured packet as one pulse. The pulse carries a length, the stored bytes, a timeout flag, a service-request flag and a flag that marks whether the packet answers the current request. Packets that the transceiver offers while the bus is idle are captured the same way. After a bus-reset command the block refuses new requests for a fixed hold-off time.

Top module: `dbus_host_seq`

## Requirements
- R1: After reset, the phase code is 11 (idle), the shift engine is set to input, no pulse output is high, and `req_ready` is 1.
- R2: An accepted request drives phase code 00 on the next cycle. In that same cycle the shift engine is set to output and command byte 0 is loaded with a one-cycle `sh_load` pulse.
- R3: When the command byte finishes, the phase code goes to 01. After that, each further byte inverts both code bits, so 01 and 10 alternate.
- R4: A request that wants no reply and whose command bits 3:2 are not 11 loads its bytes in order. When the last byte finishes, the phase code returns to 11 and `req_done` pulses.
- R5: A request that wants a reply enters reading when its last byte finishes, with the shift engine set to input and the command stored as reply byte 0. Each later byte that finishes with the status line deasserted is appended to the reply. When the status line is asserted outside the R7 and R8 cases, `rsp_valid` pulses with the byte count, `rsp_solicited`=1 and `req_done`=1, and the phase code returns to 11.
- R6: A command with bits 3:2 equal to 11 (a Talk) also enters reading when no reply was requested. In that case `req_done` pulses when the command finishes, and the packet is later reported with `rsp_solicited`=0.
- R7: While reading, if the status line is asserted at phase 01 with exactly one byte held, the timeout flag is set and reading continues. The packet is then reported with length 0.
- R8: While reading, if the status line is asserted at phase 10 with exactly two bytes held, the service-request flag is set, the byte is stored and reading continues.
- R9: The reply store keeps at most 16 bytes. Any bytes beyond that are dropped, and the reported length stays at 16.
- R10: A request whose byte count is 0 or greater than 14 is refused with a one-cycle `req_reject` pulse. The phase code stays 11 and nothing is loaded.
- R11: When a request with command 0x00 and no reply wanted completes, `req_ready` stays low for exactly HOLD_CYCLES cycles, counting from the cycle of the `req_done` pulse.
- R12: In idle, a finished byte with the status line asserted starts an unsolicited capture: that byte becomes reply byte 0 and the phase code goes to 01. A finished byte with the status line deasserted is ignored, and the phase code stays 11.
- R13: If the status line is asserted right after the command byte, the block reads a pending poll reply. The most recent Talk command that completed normally becomes reply byte 0. Once that packet ends, the pending request restarts from its command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_nbytes | input | 4 | Number of request bytes, command included |
| req_bytes | input | 112 | Request bytes, byte i at bits 8i+7:8i, byte 0 is the command |
| req_reply | input | 1 | Reply wanted |
| req_ready | output | 1 | Request would be taken this cycle |
| req_reject | output | 1 | Pulse: request refused for bad length |
| req_done | output | 1 | Pulse: current request finished |
| st_code | output | 2 | Phase code to the transceiver |
| ctlr_n | input | 1 | Controller status, active low |
| sh_dir_out | output | 1 | Shift engine direction, 1 = output |
| sh_load | output | 1 | Pulse: `sh_wdata` holds a new byte to shift out |
| sh_wdata | output | 8 | Byte to shift out |
| sh_done | input | 1 | Pulse: the shift engine finished a byte |
| sh_rdata | input | 8 | Byte shifted in |
| rsp_valid | output | 1 | Pulse: packet captured |
| rsp_len | output | 5 | Packet length, 0 on timeout |
| rsp_timeout | output | 1 | Timeout seen in the packet |
| rsp_srq | output | 1 | Service request seen in the packet |
| rsp_solicited | output | 1 | Packet answers the current request |
| rsp_bytes | output | 128 | Stored reply bytes, byte i at bits 8i+7:8i |

## Verification
Random Talk commands are run with random reply lengths both below and above the store depth. This separates correct phase alternation and appending from an off-by-one in the length bound. Random Listen-style writes of 2 to 14 bytes check the load order and the return to idle. Directed cases assert the status line at the exact byte counts where timeout, service request and plain end differ, so a swapped count or phase shows as a wrong flag or length. Further directed cases cover the pending-poll restart, idle capture against an ignored idle byte, both length rejects, and the exact width of the reset hold-off window.

// File: rtl/dbus_seq_pkg.sv
package dbus_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    localparam logic [1:0] SC_CMD  = 2'b00;
    localparam logic [1:0] SC_EVEN = 2'b01;
    localparam logic [1:0] SC_ODD  = 2'b10;
    localparam logic [1:0] SC_IDLE = 2'b11;

    // Talk operation: command bits 3:2 both set
    function automatic logic is_talk(input logic [7:0] cmd);
        return cmd[3:2] == 2'b11;
    endfunction

    // advance the phase code after a finished byte
    function automatic logic [1:0] step_code(input logic [1:0] sc);
        return (sc == SC_CMD) ? SC_EVEN : ~sc;
    endfunction

endpackage

// File: rtl/dbus_holdoff.sv
module dbus_holdoff #(
    parameter int HOLD_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = HW'(HOLD_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R11
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

// File: rtl/dbus_reply_store.sv
module dbus_reply_store #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        start_byte_i,
    input  logic              push_i,
    input  logic [7:0]        push_byte_i,
    output logic [CW-1:0]     cnt_o,
    output logic [8*DEPTH-1:0] bytes_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(1);
        else if (push_i && cnt_q < CW'(DEPTH))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [7:0] slot_d, slot_q;
        always_comb begin
            slot_d = slot_q;
            if (g == 0 && start_i)
                slot_d = start_byte_i;
            else if (!start_i && push_i && cnt_q == CW'(g))
                slot_d = push_byte_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end
        assign bytes_o[8*g +: 8] = slot_q;
    end

    assign cnt_o = cnt_q;

    // R9
    store_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/dbus_host_seq.sv
module dbus_host_seq
    import dbus_seq_pkg::*;
#(
    parameter int MAX_BYTES   = 14,
    parameter int BUF_DEPTH   = 16,
    parameter int HOLD_CYCLES = 3000,
    localparam int NW = $clog2(MAX_BYTES + 1),
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [NW-1:0]          req_nbytes,
    input  logic [8*MAX_BYTES-1:0] req_bytes,
    input  logic                   req_reply,
    output logic                   req_ready,
    output logic                   req_reject,
    output logic                   req_done,
    output logic [1:0]             st_code,
    input  logic                   ctlr_n,
    output logic                   sh_dir_out,
    output logic                   sh_load,
    output logic [7:0]             sh_wdata,
    input  logic                   sh_done,
    input  logic [7:0]             sh_rdata,
    output logic                   rsp_valid,
    output logic [CW-1:0]          rsp_len,
    output logic                   rsp_timeout,
    output logic                   rsp_srq,
    output logic                   rsp_solicited,
    output logic [8*BUF_DEPTH-1:0] rsp_bytes
);

    typedef struct packed {
        phase_e                 ph;
        logic [1:0]             sc;
        logic                   dir;
        logic                   load;
        logic [7:0]             wdata;
        logic [NW-1:0]          idx;
        logic [NW-1:0]          n;
        logic [8*MAX_BYTES-1:0] bytes;
        logic                   want;
        logic                   retry;
        logic [7:0]             last_talk;
        logic                   sol;
        logic                   tmo;
        logic                   srq;
        logic                   rsp_v;
        logic [CW-1:0]          rsp_len;
        logic                   rsp_tmo;
        logic                   rsp_srq;
        logic                   rsp_sol;
        logic                   done;
        logic                   rej;
    } seq_t;

    seq_t d, q;

    logic          hold_busy, hold_start;
    logic          buf_start, buf_push;
    logic [7:0]    buf_sbyte;
    logic [CW-1:0] buf_cnt;
    logic          ready_int, len_ok;
    logic [7:0]    cmd_q;

    assign ready_int = (q.ph == PH_IDLE) && !hold_busy && !sh_done;
    assign len_ok    = (req_nbytes != '0) && (req_nbytes <= NW'(MAX_BYTES));
    assign cmd_q     = q.bytes[7:0];

    always_comb begin
        d          = q;
        d.load     = 1'b0;
        d.rsp_v    = 1'b0;
        d.done     = 1'b0;
        d.rej      = 1'b0;
        buf_start  = 1'b0;
        buf_sbyte  = 8'h00;
        buf_push   = 1'b0;
        hold_start = 1'b0;

        unique case (q.ph)
            PH_IDLE: begin
                if (sh_done) begin
                    if (!ctlr_n) begin
                        // unsolicited packet from the transceiver
                        buf_start = 1'b1;
                        buf_sbyte = sh_rdata;
                        d.ph  = PH_READ;
                        d.sc  = SC_EVEN;
                        d.dir = 1'b0;
                        d.sol = 1'b0;
                        d.tmo = 1'b0;
                        d.srq = 1'b0;
                    end
                end else if (req_valid && ready_int) begin
                    if (!len_ok) begin
                        d.rej = 1'b1;
                    end else begin
                        d.bytes = req_bytes;
                        d.n     = req_nbytes;
                        d.want  = req_reply;
                        d.retry = 1'b0;
                        d.ph    = PH_SEND;
                        d.sc    = SC_CMD;
                        d.dir   = 1'b1;
                        d.load  = 1'b1;
                        d.wdata = req_bytes[7:0];
                        d.idx   = NW'(1);
                        d.tmo   = 1'b0;
                        d.srq   = 1'b0;
                    end
                end
            end

            PH_SEND: begin
                if (sh_done) begin
                    if (q.sc == SC_CMD && !ctlr_n) begin
                        // buffered poll reply pending; its first byte is lost
                        buf_start = 1'b1;
                        buf_sbyte = q.last_talk;
                        d.ph    = PH_READ;
                        d.dir   = 1'b0;
                        d.sc    = SC_EVEN;
                        d.sol   = 1'b0;
                        d.retry = 1'b1;
                    end else begin
                        if (q.sc == SC_CMD && is_talk(cmd_q))
                            d.last_talk = cmd_q;
                        if (q.idx >= q.n) begin
                            if (q.want || is_talk(cmd_q)) begin
                                buf_start = 1'b1;
                                buf_sbyte = cmd_q;
                                d.ph   = PH_READ;
                                d.dir  = 1'b0;
                                d.sc   = step_code(q.sc);
                                d.sol  = q.want;
                                d.done = !q.want;
                            end else begin
                                d.ph   = PH_IDLE;
                                d.sc   = SC_IDLE;
                                d.dir  = 1'b0;
                                d.done = 1'b1;
                                hold_start = (cmd_q == 8'h00);
                            end
                        end else begin
                            d.load  = 1'b1;
                            d.wdata = q.bytes[8*q.idx +: 8];
                            d.idx   = q.idx + 1'b1;
                            d.sc    = step_code(q.sc);
                        end
                    end
                end
            end

            PH_READ: begin
                if (sh_done) begin
                    if (!ctlr_n && q.sc == SC_EVEN && buf_cnt == CW'(1)) begin
                        d.tmo    = 1'b1;
                        buf_push = 1'b1;
                        d.sc     = ~q.sc;
                    end else if (!ctlr_n && q.sc == SC_ODD && buf_cnt == CW'(2)) begin
                        d.srq    = 1'b1;
                        buf_push = 1'b1;
                        d.sc     = ~q.sc;
                    end else if (!ctlr_n) begin
                        d.rsp_v   = 1'b1;
                        d.rsp_len = q.tmo ? '0 : buf_cnt;
                        d.rsp_tmo = q.tmo;
                        d.rsp_srq = q.srq;
                        d.rsp_sol = q.sol;
                        d.done    = q.sol;
                        if (q.retry) begin
                            d.retry = 1'b0;
                            d.ph    = PH_SEND;
                            d.sc    = SC_CMD;
                            d.dir   = 1'b1;
                            d.load  = 1'b1;
                            d.wdata = cmd_q;
                            d.idx   = NW'(1);
                            d.tmo   = 1'b0;
                            d.srq   = 1'b0;
                        end else begin
                            d.ph  = PH_IDLE;
                            d.sc  = SC_IDLE;
                            d.dir = 1'b0;
                        end
                    end else begin
                        buf_push = 1'b1;
                        d.sc     = ~q.sc;
                    end
                end
            end

            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
            q.sc <= SC_IDLE;
        end else begin
            q <= d;
        end
    end

    dbus_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (hold_start),
        .busy_o  (hold_busy)
    );

    dbus_reply_store #(.DEPTH(BUF_DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (buf_start),
        .start_byte_i (buf_sbyte),
        .push_i       (buf_push),
        .push_byte_i  (sh_rdata),
        .cnt_o        (buf_cnt),
        .bytes_o      (rsp_bytes)
    );

    assign req_ready     = ready_int;
    assign req_reject    = q.rej;
    assign req_done      = q.done;
    assign st_code       = q.sc;
    assign sh_dir_out    = q.dir;
    assign sh_load       = q.load;
    assign sh_wdata      = q.wdata;
    assign rsp_valid     = q.rsp_v;
    assign rsp_len       = q.rsp_len;
    assign rsp_timeout   = q.rsp_tmo;
    assign rsp_srq       = q.rsp_srq;
    assign rsp_solicited = q.rsp_sol;

    // R2
    cmd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == SC_CMD) |-> sh_dir_out);

    // R3
    read_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_READ && sh_done && ctlr_n) |=> (st_code == ~$past(st_code)));

    // R10
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (st_code == SC_IDLE && !sh_load));

    // R7
    timeout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_timeout) |-> (rsp_len == '0));

    // R12
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && sh_done && ctlr_n) |=> (st_code == SC_IDLE));

endmodule

// File: tb/dbus_host_seq_bench.sv
module dbus_host_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3000;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_reply = 0;
    logic [3:0] req_nbytes = 0;
    logic [111:0] req_bytes = '0;
    logic req_ready, req_reject, req_done;
    logic [1:0] st_code;
    logic ctlr_n = 1, sh_done = 0;
    logic [7:0] sh_rdata = 0;
    logic sh_dir_out, sh_load;
    logic [7:0] sh_wdata;
    logic rsp_valid, rsp_timeout, rsp_srq, rsp_solicited;
    logic [4:0] rsp_len;
    logic [127:0] rsp_bytes;

    int total = 0, fails = 0;
    bit finished = 0;
    logic [1:0] es;
    logic [7:0] exp_buf [16];
    int elen;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbus_host_seq #(.HOLD_CYCLES(HOLD)) u_dbus_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_nbytes(req_nbytes),
        .req_bytes(req_bytes), .req_reply(req_reply), .req_ready(req_ready),
        .req_reject(req_reject), .req_done(req_done), .st_code(st_code),
        .ctlr_n(ctlr_n), .sh_dir_out(sh_dir_out), .sh_load(sh_load),
        .sh_wdata(sh_wdata), .sh_done(sh_done), .sh_rdata(sh_rdata),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_timeout(rsp_timeout),
        .rsp_srq(rsp_srq), .rsp_solicited(rsp_solicited), .rsp_bytes(rsp_bytes)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] nxt(input logic [1:0] s);
        return (s == 2'b00) ? 2'b01 : ~s;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic pulse(input logic c, input logic [7:0] b);
        sh_done = 1; ctlr_n = c; sh_rdata = b;
        @(negedge clk);
        sh_done = 0; ctlr_n = 1;
    endtask

    task automatic send_req(input logic [111:0] bytes, input logic [3:0] n, input logic want);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_bytes = bytes; req_nbytes = n; req_reply = want;
        @(negedge clk);
        req_valid = 0;
        es = 2'b00;
        check("R2 code", {30'd0, st_code}, 32'd0);
        check("R2 dir", {31'd0, sh_dir_out}, 32'd1);
        check("R2 load", {31'd0, sh_load}, 32'd1);
        check("R2 wdata", {24'd0, sh_wdata}, {24'd0, bytes[7:0]});
    endtask

    task automatic check_bytes(input string tag);
        logic ok = 1;
        for (int i = 0; i < elen; i++)
            if (rsp_bytes[8*i +: 8] !== exp_buf[i]) ok = 0;
        check(tag, {31'd0, ok}, 32'd1);
    endtask

    // Talk with k data bytes then an end marker
    task automatic run_talk(input logic [3:0] addr, input int k, input logic want);
        logic [7:0] cmd = {addr, 4'b1100};
        logic [7:0] b;
        send_req({104'd0, cmd}, 4'd1, want);
        pulse(1, 8'h00);
        es = nxt(es);
        check("R3 after command", {30'd0, st_code}, {30'd0, es});
        check("R5 dir input", {31'd0, sh_dir_out}, 32'd0);
        check("R6 early done", {31'd0, req_done}, {31'd0, !want});
        exp_buf[0] = cmd; elen = 1;
        for (int i = 0; i < k; i++) begin
            b = 8'($urandom);
            pulse(1, b);
            if (elen < 16) begin exp_buf[elen] = b; elen++; end
            es = ~es;
            check("R3 toggle", {30'd0, st_code}, {30'd0, es});
        end
        pulse(0, 8'h00);
        check("R5 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check("R9 rsp_len", {27'd0, rsp_len}, elen);
        check("R6 solicited", {31'd0, rsp_solicited}, {31'd0, want});
        check("R5 flags", {30'd0, rsp_timeout, rsp_srq}, 32'd0);
        check("R5 done", {31'd0, req_done}, {31'd0, want});
        check("R5 idle", {30'd0, st_code}, 32'd3);
        check_bytes("R5 bytes");
    endtask

    task automatic run_listen(input logic [3:0] addr, input int n);
        logic [111:0] bytes = '0;
        bytes[7:0] = {addr, 4'b1000 | 4'($urandom % 4)};
        for (int i = 1; i < n; i++) bytes[8*i +: 8] = 8'($urandom);
        send_req(bytes, 4'(n), 1'b0);
        for (int i = 0; i < n; i++) begin
            pulse(1, 8'h00);
            if (i < n - 1) begin
                es = nxt(es);
                check("R3 send code", {30'd0, st_code}, {30'd0, es});
                check("R4 load", {31'd0, sh_load}, 32'd1);
                check("R4 wdata", {24'd0, sh_wdata}, {24'd0, bytes[8*(i+1) +: 8]});
            end else begin
                check("R4 idle", {30'd0, st_code}, 32'd3);
                check("R4 done", {31'd0, req_done}, 32'd1);
                check("R4 dir", {31'd0, sh_dir_out}, 32'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int hold_cnt;
        int seed_set;
        seed_set = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 code", {30'd0, st_code}, 32'd3);
        check("R1 dir", {31'd0, sh_dir_out}, 32'd0);
        check("R1 pulses", {28'd0, rsp_valid, req_done, req_reject, sh_load}, 32'd0);
        check("R1 ready", {31'd0, req_ready}, 32'd1);

        // R10 bad lengths
        for (int t = 0; t < 2; t++) begin
            req_valid = 1; req_nbytes = (t == 0) ? 4'd0 : 4'd15; req_bytes = 112'h2C;
            @(negedge clk);
            req_valid = 0;
            check("R10 reject", {31'd0, req_reject}, 32'd1);
            check("R10 code", {30'd0, st_code}, 32'd3);
            check("R10 load", {31'd0, sh_load}, 32'd0);
        end

        // R12 ignored idle byte, then unsolicited capture
        pulse(1, 8'h77);
        check("R12 ignored", {30'd0, st_code}, 32'd3);
        check("R12 no rsp", {31'd0, rsp_valid}, 32'd0);
        pulse(0, 8'hA5);
        check("R12 capture", {30'd0, st_code}, 32'd1);
        pulse(1, 8'h10); pulse(1, 8'h20);
        pulse(0, 8'h00);
        check("R12 rsp", {31'd0, rsp_valid}, 32'd1);
        check("R12 len", {27'd0, rsp_len}, 32'd3);
        check("R12 sol", {31'd0, rsp_solicited}, 32'd0);
        exp_buf[0] = 8'hA5; exp_buf[1] = 8'h10; exp_buf[2] = 8'h20; elen = 3;
        check_bytes("R12 bytes");

        // R7 timeout then R8 in the same packet
        send_req(112'h1C, 4'd1, 1'b1);
        pulse(1, 8'h00);
        pulse(0, 8'h00);
        check("R7 continues", {30'd0, st_code}, 32'd2);
        pulse(0, 8'h00);
        check("R8 continues", {30'd0, st_code}, 32'd1);
        pulse(0, 8'h00);
        check("R7 len zero", {27'd0, rsp_len}, 32'd0);
        check("R7 flags", {30'd0, rsp_timeout, rsp_srq}, 32'd3);

        // R8 service request alone
        send_req(112'h2C, 4'd1, 1'b1);
        pulse(1, 8'h00);
        pulse(1, 8'h41);
        pulse(0, 8'h42);
        check("R8 code", {30'd0, st_code}, 32'd1);
        pulse(1, 8'h43);
        pulse(0, 8'h00);
        check("R8 len", {27'd0, rsp_len}, 32'd4);
        check("R8 flags", {30'd0, rsp_timeout, rsp_srq}, 32'd1);
        exp_buf[0] = 8'h2C; exp_buf[1] = 8'h41; exp_buf[2] = 8'h42; exp_buf[3] = 8'h43; elen = 4;
        check_bytes("R8 bytes");

        // R13 pending poll reply after a command
        run_talk(4'h3, 2, 1'b0);
        send_req(112'h1158, 4'd2, 1'b0);
        pulse(0, 8'hEE);
        check("R13 code", {30'd0, st_code}, 32'd1);
        check("R13 dir", {31'd0, sh_dir_out}, 32'd0);
        pulse(1, 8'h61); pulse(1, 8'h62);
        pulse(0, 8'h00);
        check("R13 rsp", {31'd0, rsp_valid}, 32'd1);
        check("R13 sol", {31'd0, rsp_solicited}, 32'd0);
        exp_buf[0] = 8'h3C; exp_buf[1] = 8'h61; exp_buf[2] = 8'h62; elen = 3;
        check_bytes("R13 bytes");
        check("R13 restart code", {30'd0, st_code}, 32'd0);
        check("R13 restart load", {24'd0, sh_load, sh_wdata[6:0]}, {24'd0, 8'hD8});
        pulse(1, 8'h00);
        check("R13 second byte", {24'd0, sh_wdata}, 32'h11);
        pulse(1, 8'h00);
        check("R13 done", {31'd0, req_done}, 32'd1);

        // R9 overflow
        run_talk(4'h5, 20, 1'b1);

        // random mix
        for (int it = 0; it < 30; it++) begin
            if ($urandom % 2 == 0)
                run_talk(4'($urandom), 2 + int'($urandom % 19), 1'($urandom));
            else
                run_listen(4'($urandom), 2 + int'($urandom % 13));
        end

        // R11 bus reset hold-off
        send_req(112'h00, 4'd1, 1'b0);
        pulse(1, 8'h00);
        check("R11 done", {31'd0, req_done}, 32'd1);
        hold_cnt = 0;
        while (!req_ready && hold_cnt < HOLD + 10) begin
            hold_cnt++;
            @(negedge clk);
        end
        check("R11 hold cycles", hold_cnt, HOLD);

        finish_run();
    end
endmodule